// File: doc/BRIEF.md
# Command Ring Free-Space Monitor

This block watches a circular command ring and reports whether the producer may write a given number of bytes. It takes the consumer's read pointer, the producer's write pointer and an execution-progress pointer. From these it works out how many bytes are free. A small guard gap is always kept free, so that a completely filled ring is never mistaken for an empty one.

The producer issues a one-cycle request that carries the number of bytes it needs. The monitor then re-evaluates the free space on every poll strobe. It ends the request with a done pulse when enough room appears. It also ends the request, with a timeout flag, when the ring has stalled. A stall means that a set number of consecutive polls pass without enough room and without any movement of either the read pointer or the progress pointer. Any movement of either pointer restarts the stall count. As a result, a slow consumer that is still making progress never times out.

Top module: `ring_space_monitor`

## Requirements
- R1: While reset is asserted, and right after it, done, timeout, waiting, empty and the space value are all zero.
- R2: On each poll strobe the reported space becomes H - (T + RESERVE). If that value is negative, the ring size S is added. H is the read pointer with its low ADDR_LSB bits cleared, T is the write pointer ANDed with S-1, RESERVE defaults to 8, and S is a power of two.
- R3: When the space at a poll strobe is at least the requested byte count, done pulses for exactly one cycle after that strobe's edge, timeout is 0, and the space value shows the space that satisfied the request.
- R4: After STALL_LIMIT consecutive unsatisfied polls with neither pointer moving, done pulses with timeout 1. Timeout is never high without done.
- R5: A poll that sees a read pointer different from the one seen at the previous poll (or at request time) restarts the stall count from zero.
- R6: A poll that sees a progress pointer different from its previous sample also restarts the stall count.
- R7: The waiting output rises in the cycle after an accepted request and falls in the cycle in which done pulses.
- R8: At each poll strobe, empty is set when the masked read pointer equals the masked write pointer, and is cleared otherwise.
- R9: A request pulse that arrives while a request is already waiting is ignored. The pending byte count and the stall count are kept.
- R10: Between poll strobes the space and empty outputs hold their values. A poll strobe with no pending request updates them but does not produce done.
- R11: The low ADDR_LSB bits of the read pointer (2 by default) have no effect on the space value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request for space |
| req_bytes_i | input | PTR_W | Bytes needed by the request |
| head_i | input | PTR_W | Consumer read pointer (byte address) |
| tail_i | input | PTR_W | Producer write pointer (byte address) |
| act_head_i | input | ACT_W | Execution-progress pointer |
| ring_size_i | input | PTR_W+1 | Ring size in bytes, a power of two |
| tick_i | input | 1 | Poll strobe |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | With done: the request ended in a stall |
| waiting_o | output | 1 | A request is pending and not yet satisfied |
| empty_o | output | 1 | Read and write pointers were equal at the last poll |
| space_o | output | PTR_W+2 | Signed free space sampled at the last poll |

## Verification
The bound checker checks the following on every cycle:
- done and timeout always pulse together, and neither lasts more than one cycle.
- done only follows a waiting cycle that held a poll strobe.
- waiting only starts after a request.
- space and empty stay frozen between strobes.
- an empty ring always reports the size minus the guard gap.

Only the bench scenarios can show the rest:
- the arithmetic values across wrap and masking.
- the exact poll on which a stall expires.
- the restart of the count by each kind of pointer movement.
- that a second request during a wait is discarded.

// File: rtl/ring_mon_pkg.sv
package ring_mon_pkg;
   typedef enum logic [0:0] {
      MON_IDLE = 1'b0,
      MON_WAIT = 1'b1
   } mon_state_e;
endpackage

// File: rtl/ring_space_calc.sv
module ring_space_calc #(
   parameter int PTR_W    = 21,
   parameter int ADDR_LSB = 2,
   parameter int RESERVE  = 8,
   localparam int SW      = PTR_W + 2
) (
   input  logic [PTR_W-1:0]     head_i,
   input  logic [PTR_W-1:0]     tail_i,
   input  logic [PTR_W:0]       ring_size_i,
   output logic [PTR_W-1:0]     head_addr_o,
   output logic signed [SW-1:0] space_o,
   output logic                 empty_o
);
   localparam logic [PTR_W-1:0]     ONE    = {{(PTR_W-1){1'b0}}, 1'b1};
   localparam logic [PTR_W-1:0]     LOW_M  = PTR_W'((64'd1 << ADDR_LSB) - 64'd1);
   localparam logic [PTR_W-1:0]     HEAD_M = ~LOW_M;
   localparam logic signed [SW-1:0] RES_S  = SW'(RESERVE);

   logic [PTR_W-1:0]     tail_addr;
   logic [PTR_W-1:0]     wrap_mask;
   logic signed [SW-1:0] diff;

   generate
      if (ADDR_LSB == 0) begin : g_head_full
         assign head_addr_o = head_i;
      end else begin : g_head_masked
         assign head_addr_o = head_i & HEAD_M;
      end
   endgenerate

   // size is a power of two: its low bits minus one give the wrap mask
   assign wrap_mask = ring_size_i[PTR_W-1:0] - ONE;
   assign tail_addr = tail_i & wrap_mask;

   always_comb begin
      diff = $signed({2'b00, head_addr_o}) - $signed({2'b00, tail_addr}) - RES_S;
      if (diff[SW-1])
         space_o = diff + $signed({1'b0, ring_size_i});
      else
         space_o = diff;
   end

   assign empty_o = (head_addr_o == tail_addr);
endmodule

// File: rtl/ring_stall_watch.sv
module ring_stall_watch #(
   parameter int PTR_W       = 21,
   parameter int ACT_W       = 32,
   parameter int STALL_LIMIT = 100000,
   localparam int CNT_W      = $clog2(STALL_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             poll_i,
   input  logic             sample_i,
   input  logic [PTR_W-1:0] head_addr_i,
   input  logic [ACT_W-1:0] act_i,
   output logic             expire_o
);
   logic [PTR_W-1:0] last_head;
   logic [ACT_W-1:0] last_act;
   logic             progress;

   assign progress = (head_addr_i != last_head) || (act_i != last_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_head <= '0;
         last_act  <= '0;
      end else if (arm_i || sample_i) begin
         last_head <= head_addr_i;
         last_act  <= act_i;
      end
   end

   generate
      if (STALL_LIMIT == 1) begin : g_no_count
         assign expire_o = poll_i && !progress;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STALL_LIMIT - 1);
         logic [CNT_W-1:0] cnt;

         assign expire_o = poll_i && !progress && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (arm_i)
               cnt <= '0;
            else if (poll_i) begin
               if (progress)
                  cnt <= '0;
               else if (cnt != LAST)
                  cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ring_space_monitor.sv
module ring_space_monitor #(
   parameter int PTR_W       = 21,
   parameter int ADDR_LSB    = 2,
   parameter int ACT_W       = 32,
   parameter int RESERVE     = 8,
   parameter int STALL_LIMIT = 100000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_i,
   input  logic [PTR_W-1:0]          req_bytes_i,
   input  logic [PTR_W-1:0]          head_i,
   input  logic [PTR_W-1:0]          tail_i,
   input  logic [ACT_W-1:0]          act_head_i,
   input  logic [PTR_W:0]            ring_size_i,
   input  logic                      tick_i,
   output logic                      done_o,
   output logic                      timeout_o,
   output logic                      waiting_o,
   output logic                      empty_o,
   output logic signed [PTR_W+1:0]   space_o
);
   import ring_mon_pkg::*;

   localparam int SW = PTR_W + 2;

   generate
      if (PTR_W < 4) begin : g_bad_ptr
         $error("PTR_W must be at least 4");
      end
      if (ADDR_LSB < 0 || ADDR_LSB >= PTR_W) begin : g_bad_lsb
         $error("ADDR_LSB must lie inside the pointer");
      end
      if (STALL_LIMIT < 1) begin : g_bad_limit
         $error("STALL_LIMIT must be positive");
      end
      if (RESERVE < 0 || RESERVE >= (1 << (PTR_W - 1))) begin : g_bad_res
         $error("RESERVE out of range");
      end
   endgenerate

   mon_state_e           state;
   logic [PTR_W-1:0]     need_q;
   logic                 done_q, timeout_q, empty_q;
   logic signed [SW-1:0] space_q;

   logic [PTR_W-1:0]     head_addr;
   logic signed [SW-1:0] space_w;
   logic                 empty_w;
   logic                 accept, sat, wait_tick, poll_miss, expire;

   ring_space_calc #(
      .PTR_W(PTR_W), .ADDR_LSB(ADDR_LSB), .RESERVE(RESERVE)
   ) u_calc (
      .head_i(head_i), .tail_i(tail_i), .ring_size_i(ring_size_i),
      .head_addr_o(head_addr), .space_o(space_w), .empty_o(empty_w)
   );

   assign accept    = req_i && (state == MON_IDLE);
   assign wait_tick = tick_i && (state == MON_WAIT);
   assign sat       = space_w >= $signed({2'b00, need_q});
   assign poll_miss = wait_tick && !sat;

   ring_stall_watch #(
      .PTR_W(PTR_W), .ACT_W(ACT_W), .STALL_LIMIT(STALL_LIMIT)
   ) u_watch (
      .clk(clk), .rst_n(rst_n), .arm_i(accept), .poll_i(poll_miss),
      .sample_i(wait_tick), .head_addr_i(head_addr), .act_i(act_head_i),
      .expire_o(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= MON_IDLE;
         need_q    <= '0;
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
         space_q   <= '0;
         empty_q   <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
         if (tick_i) begin
            space_q <= space_w;
            empty_q <= empty_w;
         end
         if (accept) begin
            state  <= MON_WAIT;
            need_q <= req_bytes_i;
         end else if (wait_tick) begin
            if (sat) begin
               state  <= MON_IDLE;
               done_q <= 1'b1;
            end else if (expire) begin
               state     <= MON_IDLE;
               done_q    <= 1'b1;
               timeout_q <= 1'b1;
            end
         end
      end
   end

   assign done_o    = done_q;
   assign timeout_o = timeout_q;
   assign waiting_o = (state == MON_WAIT);
   assign empty_o   = empty_q;
   assign space_o   = space_q;
endmodule

// File: rtl/ring_space_monitor_chk.sv
module ring_space_monitor_chk #(
   parameter int PTR_W   = 21,
   parameter int RESERVE = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_i,
   input logic                    tick_i,
   input logic [PTR_W:0]          ring_size_i,
   input logic                    done_o,
   input logic                    timeout_o,
   input logic                    waiting_o,
   input logic                    empty_o,
   input logic signed [PTR_W+1:0] space_o
);
   localparam logic signed [PTR_W+1:0] RES_S = (PTR_W+2)'(RESERVE);

   // R4
   timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> done_o);

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(waiting_o) && !waiting_o));

   // R3
   done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tick_i));

   // R7
   wait_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(waiting_o) |-> $past(req_i));

   // R10
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_i) |-> ($stable(space_o) && $stable(empty_o)));

   // R8
   empty_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick_i) && empty_o && $stable(ring_size_i))
         |-> (space_o == $signed({1'b0, ring_size_i}) - RES_S));
endmodule

bind ring_space_monitor ring_space_monitor_chk #(
   .PTR_W(PTR_W), .RESERVE(RESERVE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .tick_i(tick_i),
   .ring_size_i(ring_size_i), .done_o(done_o), .timeout_o(timeout_o),
   .waiting_o(waiting_o), .empty_o(empty_o), .space_o(space_o)
);

// File: tb/ring_space_monitor_tb.sv
module ring_space_monitor_tb;
   localparam int PTR_W = 12;
   localparam int ACT_W = 32;
   localparam int LIMIT = 5;
   localparam int SW    = PTR_W + 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_i = 1'b0;
   logic [PTR_W-1:0]     req_bytes_i = '0;
   logic [PTR_W-1:0]     head_i = '0;
   logic [PTR_W-1:0]     tail_i = '0;
   logic [ACT_W-1:0]     act_head_i = '0;
   logic [PTR_W:0]       ring_size_i = 13'd256;
   logic                 tick_i = 1'b0;
   logic                 done_o, timeout_o, waiting_o, empty_o;
   logic signed [SW-1:0] space_o;

   int checks = 0;
   int errors = 0;

   typedef struct packed {
      logic                 to;
      logic signed [SW-1:0] sp;
   } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   ring_space_monitor #(
      .PTR_W(PTR_W), .ADDR_LSB(2), .ACT_W(ACT_W), .RESERVE(8), .STALL_LIMIT(LIMIT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_bytes_i(req_bytes_i),
      .head_i(head_i), .tail_i(tail_i), .act_head_i(act_head_i),
      .ring_size_i(ring_size_i), .tick_i(tick_i), .done_o(done_o),
      .timeout_o(timeout_o), .waiting_o(waiting_o), .empty_o(empty_o),
      .space_o(space_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_done(input logic to, input int sp, input string tag);
      exp_t e;
      e.to = to;
      e.sp = SW'(sp);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic tick_once();
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
   endtask

   task automatic request(input int bytes);
      @(negedge clk);
      req_i = 1'b1;
      req_bytes_i = PTR_W'(bytes);
      @(negedge clk) req_i = 1'b0;
   endtask

   // monitor: pops expected completions in order
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R4 unexpected done", 1, 0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(timeout_o == e.to, {t, " timeout"}, int'(timeout_o), int'(e.to));
            chk(space_o == e.sp, {t, " space"}, int'(space_o), int'(e.sp));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!done_o && !timeout_o && !waiting_o && !empty_o, "R1 flags", 
          int'({done_o, timeout_o, waiting_o, empty_o}), 0);
      chk(space_o == 0, "R1 space", int'(space_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!waiting_o && space_o == 0, "R1 after release", int'(waiting_o), 0);

      // R10: idle poll updates space, no done
      head_i = 12'h080; tail_i = 12'h010;
      tick_once();
      chk(space_o == 104, "R10 R2 idle space", int'(space_o), 104);
      chk(!empty_o, "R8 not empty", int'(empty_o), 0);
      chk(!waiting_o, "R10 idle", int'(waiting_o), 0);
      repeat (3) @(negedge clk);
      chk(space_o == 104, "R10 hold", int'(space_o), 104);

      // R3 R7: straightforward success
      request(64);
      chk(waiting_o, "R7 waiting after req", int'(waiting_o), 1);
      expect_done(1'b0, 104, "R3 success");
      tick_once();
      chk(!waiting_o, "R7 waiting cleared", int'(waiting_o), 0);

      // R2: wrapped pointers 32 - 200 + 256 = 88
      head_i = 12'h020; tail_i = 12'h0C0;
      request(80);
      expect_done(1'b0, 88, "R2 wrap");
      tick_once();

      // R11 R2: head low bits and tail upper bits masked: 0x88 - 0x80 = 8
      head_i = 12'h08B; tail_i = 12'h178;
      request(8);
      expect_done(1'b0, 8, "R11 mask");
      tick_once();

      // R4 R8: stall on an empty ring, space 248
      head_i = 12'h040; tail_i = 12'h040;
      request(300);
      tick_once();
      chk(empty_o, "R8 empty", int'(empty_o), 1);
      chk(waiting_o, "R4 still waiting", int'(waiting_o), 1);
      repeat (3) tick_once();
      chk(waiting_o, "R4 no early timeout", int'(waiting_o), 1);
      expect_done(1'b1, 248, "R4 stall");
      tick_once();

      // R5: head movement restarts the count
      request(300);
      repeat (3) tick_once();
      head_i = 12'h050;
      tick_once();
      repeat (4) tick_once();
      chk(waiting_o, "R5 restart by head", int'(waiting_o), 1);
      expect_done(1'b1, 8, "R5 stall after head move");
      tick_once();

      // R6: progress-pointer movement restarts the count
      head_i = 12'h040;
      request(300);
      repeat (3) tick_once();
      act_head_i = 32'h1234;
      tick_once();
      repeat (4) tick_once();
      chk(waiting_o, "R6 restart by progress", int'(waiting_o), 1);
      expect_done(1'b1, 248, "R6 stall after progress");
      tick_once();

      // R9: second request while waiting is ignored
      request(300);
      repeat (2) tick_once();
      request(4);
      repeat (2) tick_once();
      chk(waiting_o, "R9 second req ignored", int'(waiting_o), 1);
      expect_done(1'b1, 248, "R9 kept count");
      tick_once();

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3/R4 missing done", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule